// File: doc/BRIEF.md
# Receive FIFO Pause-Trigger Generator

This block decides when a receive path should ask the transmitter for an automatic PAUSE frame. It watches two live occupancy counts of an Ethernet receive FIFO: the number of stored bytes and the number of complete stored frames. Each count is compared against its own programmable limit. If either limit is reached, a pause request is raised.

Software programs the two limits through one 32-bit register. A 3-bit frame code sets the frame limit, in steps of two frames. A 3-bit level code selects a byte limit in 256-byte units. When the level code equals the configured FIFO size code, the byte limit moves down to leave 64 bytes of headroom. Software must keep the level code at or below the FIFO size code. The request is a registered level that follows the occupancy with one clock of latency.

Top module: `rx_pause_trigger`

## Requirements
- R1: After a synchronous active-high reset, `cfg_rd_data` reads 0x0007_0000. This means frame code 111 and level code 000.
- R2: The frame code is at bits 18:16 and the level code is at bits 2:0. A write with `cfg_wr_en` high updates both fields at the next rising edge, and `cfg_rd_data` then returns them. Without a write, the register holds its value.
- R3: All bits other than 18:16 and 2:0 always read as 0, and writing them has no effect.
- R4: The frame condition is true when `fill_frames` >= 2 × (frame code + 1). Code 0 means 2 frames, and code 7 means 16 frames.
- R5: When the level code n is less than `fifo_depth_code`, the byte condition is true when `fill_bytes` >= (n + 1) × 256.
- R6: When the level code n equals `fifo_depth_code`, the byte condition is true when `fill_bytes` >= (n + 1) × 256 − 64. For example, code 0 gives 192 bytes.
- R7: `pause_req` is the OR of the two conditions, so each condition raises it on its own. It falls once both conditions are false.
- R8: `pause_req` is registered. It reflects the inputs and configuration sampled at the preceding rising edge, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Register read data |
| fifo_depth_code | input | 3 | Configured FIFO size code, (code + 1) × 256 bytes |
| fill_bytes | input | 12 | Bytes currently stored in the receive FIFO |
| fill_frames | input | 5 | Complete frames currently stored |
| pause_req | output | 1 | Automatic PAUSE request level |

## Verification
The frame code is swept through all eight values. Each value is tried exactly at its limit and one frame below it, which separates `>=` from `>` and shows the step of two frames. The byte level is tried at every code in two cases: with the level code equal to the FIFO size code, and with the level code smaller than it. Each case is probed at the limit and one byte below, so a headroom applied to the wrong case shows up as a 64-byte shift. Separate patterns raise the request from only one condition, then remove both conditions. A latency probe shows that the request changes only at the clock edge.

// File: rtl/pause_trig_pkg.sv
package pause_trig_pkg;
    localparam int CODE_W  = 3;
    localparam int FRM_LSB = 16;
    localparam int LVL_LSB = 0;
    localparam int REG_W   = 32;

    typedef struct packed {
        logic [CODE_W-1:0] frm_code;
        logic [CODE_W-1:0] lvl_code;
    } thr_cfg_t;

    typedef struct packed {
        logic pause;
    } trig_state_t;
endpackage

// File: rtl/pause_thr_regs.sv
module pause_thr_regs
    import pause_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output thr_cfg_t         cfg
);
    thr_cfg_t cfg_d, cfg_q;
    logic     unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.frm_code = wr_data[FRM_LSB +: CODE_W];
            cfg_d.lvl_code = wr_data[LVL_LSB +: CODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.frm_code <= '1;
            cfg_q.lvl_code <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[FRM_LSB +: CODE_W] = cfg_q.frm_code;
        rd_data[LVL_LSB +: CODE_W] = cfg_q.lvl_code;
    end

    assign cfg = cfg_q;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[FRM_LSB +: CODE_W] == $past(wr_data[FRM_LSB +: CODE_W]))
               && (rd_data[LVL_LSB +: CODE_W] == $past(wr_data[LVL_LSB +: CODE_W])));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 32'h0007_0000) || $past(!rst) || rst);

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_data) <= 2 * CODE_W);
endmodule

// File: rtl/pause_byte_cmp.sv
module pause_byte_cmp
    import pause_trig_pkg::*;
#(
    parameter int BYTE_W     = 12,
    parameter int UNIT_BYTES = 256,
    parameter int HEADROOM   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] lvl_code,
    input  logic [CODE_W-1:0] depth_code,
    input  logic [BYTE_W-1:0] fill_bytes,
    output logic              hit
);
    localparam int LIM_W = BYTE_W + 1;

    logic [LIM_W-1:0] base_lim;
    logic [LIM_W-1:0] limit;
    logic             at_top;

    always_comb begin
        base_lim = LIM_W'((32'(lvl_code) + 32'd1) * 32'(UNIT_BYTES));
        at_top   = (lvl_code == depth_code);
        limit    = at_top ? (base_lim - LIM_W'(HEADROOM)) : base_lim;
        hit      = ({1'b0, fill_bytes} >= limit);
    end

    assert_byte_floor_R6: assert property (@(posedge clk) disable iff (rst)
        hit |-> (32'(fill_bytes) >= UNIT_BYTES - HEADROOM));

    assert_byte_full_unit_R5: assert property (@(posedge clk) disable iff (rst)
        (lvl_code < depth_code) && hit |-> (32'(fill_bytes) >= UNIT_BYTES));
endmodule

// File: rtl/pause_frame_cmp.sv
module pause_frame_cmp
    import pause_trig_pkg::*;
#(
    parameter int FRAME_W    = 5,
    parameter int FRAME_STEP = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  frm_code,
    input  logic [FRAME_W-1:0] fill_frames,
    output logic               hit
);
    localparam int FCMP_W = FRAME_W + 1;

    logic [FCMP_W-1:0] need;

    always_comb begin
        need = FCMP_W'((32'(frm_code) + 32'd1) * 32'(FRAME_STEP));
        hit  = ({1'b0, fill_frames} >= need);
    end

    assert_frame_floor_R4: assert property (@(posedge clk) disable iff (rst)
        hit |-> (32'(fill_frames) >= FRAME_STEP));

    assert_frame_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
        (32'(fill_frames) >= (1 << CODE_W) * FRAME_STEP) |-> hit);
endmodule

// File: rtl/rx_pause_trigger.sv
module rx_pause_trigger
    import pause_trig_pkg::*;
#(
    parameter int BYTE_W     = 12,
    parameter int FRAME_W    = 5,
    parameter int UNIT_BYTES = 256,
    parameter int HEADROOM   = 64,
    parameter int FRAME_STEP = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic [31:0]        cfg_wr_data,
    output logic [31:0]        cfg_rd_data,
    input  logic [2:0]         fifo_depth_code,
    input  logic [BYTE_W-1:0]  fill_bytes,
    input  logic [FRAME_W-1:0] fill_frames,
    output logic               pause_req
);
    thr_cfg_t    cfg;
    logic        byte_hit, frame_hit;
    trig_state_t st_d, st_q;

    pause_thr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    pause_byte_cmp #(
        .BYTE_W     (BYTE_W),
        .UNIT_BYTES (UNIT_BYTES),
        .HEADROOM   (HEADROOM)
    ) u_byte (
        .clk        (clk),
        .rst        (rst),
        .lvl_code   (cfg.lvl_code),
        .depth_code (fifo_depth_code),
        .fill_bytes (fill_bytes),
        .hit        (byte_hit)
    );

    pause_frame_cmp #(
        .FRAME_W    (FRAME_W),
        .FRAME_STEP (FRAME_STEP)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .frm_code    (cfg.frm_code),
        .fill_frames (fill_frames),
        .hit         (frame_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pause = byte_hit | frame_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pause_req = st_q.pause;

    assert_either_raises_R7: assert property (@(posedge clk) disable iff (rst)
        (byte_hit || frame_hit) |=> pause_req);

    assert_both_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (!byte_hit && !frame_hit) |=> !pause_req);

    assert_quiet_in_reset_R8: assert property (@(posedge clk)
        rst |=> !pause_req || !$past(rst) || !rst);
endmodule

// File: tb/rx_pause_trigger_tb.sv
module rx_pause_trigger_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [2:0]  fifo_depth_code = 3'd0;
    logic [11:0] fill_bytes = '0;
    logic [4:0]  fill_frames = '0;
    logic        pause_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rx_pause_trigger dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_wr_data     (cfg_wr_data),
        .cfg_rd_data     (cfg_rd_data),
        .fifo_depth_code (fifo_depth_code),
        .fill_bytes      (fill_bytes),
        .fill_frames     (fill_frames),
        .pause_req       (pause_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] val);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = val;
        @(posedge clk);
        #1;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic apply(input logic [2:0] dep, input int nb, input int nf);
        @(negedge clk);
        fifo_depth_code = dep;
        fill_bytes      = 12'(nb);
        fill_frames     = 5'(nf);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        check("R1 reset reg", cfg_rd_data, 32'h0007_0000);
        check("R8 reset pause", {31'd0, pause_req}, 32'd0);
    endtask

    task automatic t_regs;
        write_cfg(32'h0005_0003);
        check("R2 fields", cfg_rd_data, 32'h0005_0003);
        write_cfg(32'hFFF8_FFF8);
        check("R3 reserved ignored", cfg_rd_data, 32'h0000_0000);
        write_cfg(32'hFFFF_FFFF);
        check("R3 reserved read zero", cfg_rd_data, 32'h0007_0007);
        repeat (3) @(posedge clk);
        #1;
        check("R2 hold", cfg_rd_data, 32'h0007_0007);
    endtask

    task automatic t_frames;
        for (int c = 0; c < 8; c++) begin
            write_cfg({13'd0, 3'(c), 13'd0, 3'd0});
            apply(3'd7, 0, 2 * (c + 1) - 1);
            check($sformatf("R4 code %0d below", c), {31'd0, pause_req}, 32'd0);
            apply(3'd7, 0, 2 * (c + 1));
            check($sformatf("R4 code %0d at", c), {31'd0, pause_req}, 32'd1);
        end
    endtask

    task automatic t_bytes;
        for (int n = 0; n < 8; n++) begin
            write_cfg({13'd0, 3'd7, 13'd0, 3'(n)});
            apply(3'(n), (n + 1) * 256 - 65, 0);
            check($sformatf("R6 code %0d below", n), {31'd0, pause_req}, 32'd0);
            apply(3'(n), (n + 1) * 256 - 64, 0);
            check($sformatf("R6 code %0d at", n), {31'd0, pause_req}, 32'd1);
            if (n < 7) begin
                apply(3'd7, (n + 1) * 256 - 1, 0);
                check($sformatf("R5 code %0d below", n), {31'd0, pause_req}, 32'd0);
                apply(3'd7, (n + 1) * 256, 0);
                check($sformatf("R5 code %0d at", n), {31'd0, pause_req}, 32'd1);
            end
        end
    endtask

    task automatic t_or;
        write_cfg(32'h0001_0001);
        apply(3'd3, 100, 4);
        check("R7 frame alone", {31'd0, pause_req}, 32'd1);
        apply(3'd3, 512, 1);
        check("R7 byte alone", {31'd0, pause_req}, 32'd1);
        apply(3'd3, 600, 9);
        check("R7 both", {31'd0, pause_req}, 32'd1);
        apply(3'd3, 100, 1);
        check("R7 both clear", {31'd0, pause_req}, 32'd0);
    endtask

    task automatic t_latency;
        write_cfg(32'h0000_0000);
        apply(3'd0, 0, 0);
        @(negedge clk);
        fill_frames = 5'd2;
        #1;
        check("R8 before edge", {31'd0, pause_req}, 32'd0);
        @(posedge clk);
        #1;
        check("R8 after edge", {31'd0, pause_req}, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_regs();
        t_frames();
        t_bytes();
        t_or();
        t_latency();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule